// File: doc/BRIEF.md
# Embedded-Operation Toggle Status Generator

This block sits on the read path of a flash array and decides what byte a read returns while an internal program or erase runs. It keeps two toggle flip-flops. Each one inverts on a read strobe when its own condition holds, so host software can tell the device state from two consecutive reads.

The primary toggle, on bit 6, flips on every read while a program or an active erase is running. It also flips during a short timed window that follows a program aimed at a protected sector. It does not flip while an erase is merely suspended, and that is how the mode is told apart. The secondary toggle, on bit 2, flips only for reads whose sector index is marked for erase. It does this whether the erase is running or suspended, and that is how the sector is told apart.

When neither toggle condition holds for a read, the read returns the array data byte unchanged. The result of a read is registered and holds until the next read strobe.

Top module: `toggle_status_gen`

## Requirements
- R1: After reset, `status` is 0x00, both toggle bits are 0 and no protected-sector window is running.
- R2: A read strobe taken while `busy_prog` or `busy_erase` is high inverts the primary toggle. The returned byte carries that toggle in bit 6 and the secondary toggle in bit 2, and bits 7, 5, 4, 3, 1 and 0 read 0.
- R3: Two back-to-back reads taken while the primary toggle condition holds return opposite values in bit 6.
- R4: The secondary toggle (bit 2) inverts on a read only when `erase_sel[rd_sector]` is 1 and either `busy_erase` or `erase_susp` is high. On any other read it keeps its value.
- R5: With `erase_susp` high and `busy_prog`, `busy_erase` and the protected window all inactive, bit 6 keeps its value across reads. A read in a sector not marked for erase returns `array_data`.
- R6: A read taken with `busy_prog` high while `erase_susp` is high inverts bit 6.
- R7: A `prot_start` pulse opens a window of PROT_CYCLES clock cycles. A read latched on any of the PROT_CYCLES edges after the pulse edge inverts bit 6. The first read after the window returns `array_data`, provided no other toggle condition holds.
- R8: A read with no toggle condition active returns the `array_data` byte present at the strobe.
- R9: `status` changes only on the clock edge that latches a read strobe. In every other cycle it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | Single-cycle read strobe |
| rd_sector | input | SEC_W | Sector index of the read address |
| erase_sel | input | SECTORS | One bit per sector, 1 = marked for erase |
| busy_prog | input | 1 | Embedded program running |
| busy_erase | input | 1 | Embedded erase actively running |
| erase_susp | input | 1 | Erase suspended |
| prot_start | input | 1 | Pulse: program command hit a protected sector |
| array_data | input | 8 | Array data byte for pass-through |
| status | output | 8 | Byte returned by the read |

## Verification
The bench builds the block with SECTORS=8 and PROT_CYCLES=20. A short window lets the run reach the expiry of the protected-sector window, and the exact last edge of that window, in a few dozen cycles. Eight sectors are enough to mix marked and unmarked sector indexes in the same sequence. With these values the bench steps through every flag combination: active erase, suspend only, program during suspend, protected window and idle. It also checks the read that lands on the final window edge against the read one edge later.

// File: rtl/toggle_status_gen.sv
module toggle_status_gen #(
  parameter int SECTORS     = 16,
  parameter int PROT_CYCLES = 100
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    rd_stb,
  input  logic [(SECTORS>1?$clog2(SECTORS):1)-1:0] rd_sector,
  input  logic [SECTORS-1:0]                      erase_sel,
  input  logic                                    busy_prog,
  input  logic                                    busy_erase,
  input  logic                                    erase_susp,
  input  logic                                    prot_start,
  input  logic [7:0]                              array_data,
  output logic [7:0]                              status
);
  localparam int SEC_W = (SECTORS > 1) ? $clog2(SECTORS) : 1;
  localparam int CNT_W = $clog2(PROT_CYCLES + 1);

  logic [CNT_W-1:0] win_cnt;
  logic             t6, t2;
  logic             prot_busy, in_sel, tog6, tog2, n6, n2;

  assign prot_busy = (win_cnt != '0);
  assign in_sel    = (int'(rd_sector) < SECTORS) ? erase_sel[rd_sector] : 1'b0;
  assign tog6      = busy_prog | busy_erase | prot_busy;
  assign tog2      = (busy_erase | erase_susp) & in_sel;
  assign n6        = t6 ^ tog6;
  assign n2        = t2 ^ tog2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt <= '0;
    end else if (prot_start) begin
      win_cnt <= CNT_W'(PROT_CYCLES);
    end else if (prot_busy) begin
      win_cnt <= win_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t6     <= 1'b0;
      t2     <= 1'b0;
      status <= 8'h00;
    end else if (rd_stb) begin
      t6     <= n6;
      t2     <= n2;
      status <= (tog6 | tog2) ? {1'b0, n6, 3'b000, n2, 2'b00} : array_data;
    end
  end

  AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(status)); // R9
  AST_B6_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (busy_prog || busy_erase)) |=> (status[6] != $past(t6))); // R2
  AST_B2_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !in_sel) |=> (t2 == $past(t2))); // R4
  AST_SUSP_B6_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && erase_susp && !busy_prog && !busy_erase && !prot_busy) |=> $stable(t6)); // R5
  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(win_cnt) <= PROT_CYCLES)); // R7
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !busy_prog && !busy_erase && !erase_susp && !prot_busy) |=> (status == $past(array_data))); // R8
endmodule

// File: tb/test_toggle_status_gen.sv
`timescale 1ns/1ps
module test_toggle_status_gen;
  localparam int SECTORS = 8;
  localparam int PROT    = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_stb = 1'b0;
  logic [2:0] rd_sector = '0;
  logic [7:0] erase_sel = '0;
  logic       busy_prog = 1'b0, busy_erase = 1'b0, erase_susp = 1'b0, prot_start = 1'b0;
  logic [7:0] array_data = 8'hA5;
  logic [7:0] status;

  int checks = 0, failures = 0;

  toggle_status_gen #(.SECTORS(SECTORS), .PROT_CYCLES(PROT)) i_toggle_status_gen (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_sector(rd_sector),
    .erase_sel(erase_sel), .busy_prog(busy_prog), .busy_erase(busy_erase),
    .erase_susp(erase_susp), .prot_start(prot_start), .array_data(array_data),
    .status(status));

  always #2 clk = ~clk;

  // behavioural reference
  int   m6 = 0, m2 = 0, mcnt = 0;
  logic [7:0] ms = 8'h00;
  always @(posedge clk) begin
    if (!rst_n) begin
      m6 = 0; m2 = 0; mcnt = 0; ms = 8'h00;
    end else begin
      if (rd_stb) begin
        bit a6, a2;
        a6 = busy_prog || busy_erase || (mcnt > 0);
        a2 = (busy_erase || erase_susp) && erase_sel[rd_sector];
        if (a6) m6 = 1 - m6;
        if (a2) m2 = 1 - m2;
        ms = (a6 || a2) ? 8'((m6 << 6) | (m2 << 2)) : array_data;
      end
      if (prot_start) mcnt = PROT;
      else if (mcnt > 0) mcnt = mcnt - 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (status !== ms) begin
        failures++;
        $display("FAIL R9 model compare: status=%h expected=%h", status, ms);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] exp);
    checks++;
    if (status !== exp) begin
      failures++;
      $display("FAIL %s: status=%h expected=%h", req, status, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the strobe is latched
  task automatic rd(input logic [2:0] sec);
    rd_sector = sec; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic pulse_prot();
    prot_start = 1'b1;
    @(negedge clk);
    prot_start = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 8'h00);

    rd(3'd1); chk("R8 idle pass", 8'hA5);
    array_data = 8'h3C;
    repeat (4) @(negedge clk);
    chk("R9 hold without read", 8'hA5);

    busy_erase = 1'b1; erase_sel = 8'b0000_0100;
    rd(3'd2); chk("R2 R4 erase sel read1", 8'h44);
    rd(3'd2); chk("R3 erase sel read2", 8'h00);
    rd(3'd5); chk("R4 unselected sector", 8'h40);

    busy_erase = 1'b0; erase_susp = 1'b1;
    rd(3'd2); chk("R5 susp sel read1", 8'h44);
    rd(3'd2); chk("R5 susp sel read2 b6 held", 8'h40);
    rd(3'd5); chk("R5 susp unselected pass", 8'h3C);

    busy_prog = 1'b1;
    rd(3'd5); chk("R6 prog in susp read1", 8'h00);
    rd(3'd5); chk("R6 prog in susp read2", 8'h40);

    busy_prog = 1'b0; erase_susp = 1'b0; erase_sel = '0;
    pulse_prot();
    rd(3'd0); chk("R7 window read1", 8'h00);
    rd(3'd0); chk("R7 window read2", 8'h40);
    repeat (PROT + 5) @(negedge clk);
    rd(3'd0); chk("R7 after window", 8'h3C);

    pulse_prot();
    repeat (PROT - 1) @(negedge clk);
    rd(3'd0); chk("R7 last window edge", 8'h00);
    rd(3'd0); chk("R7 first edge after window", 8'h3C);

    array_data = 8'h81;
    rd(3'd7); chk("R8 idle pass new data", 8'h81);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule